// File: doc/BRIEF.md
# Reservation Monitor for Atomic Load-Reserve / Store-Conditional

This block stands in front of a small shared word memory that two requesting threads or cores use. Apart from plain reads and writes, it offers a load-reserve operation, which returns a word and records that the requester now holds a reservation on that address. It also offers a conditional store, which writes only while the reservation is still intact. In place of store data, the conditional store hands back a one-bit status zero-extended to the word width: 1 when the store happened and 0 when it was refused. Software builds atomic swaps, test-and-set locks and similar primitives by retrying the pair of operations until the conditional store reports success.

Each requester has its own valid/ready handshake. When both requesters are valid in the same cycle, a fixed-priority arbiter accepts exactly one of them, so the memory access and the reservation update of one operation never interleave with another's. The response arrives on a per-requester return port one cycle after the request is accepted.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, every memory word reads 0, no requester holds a reservation (a conditional store straight after reset returns 0), and both response valids are low.
- R2: Operation codes are read = 0, write = 1, load-reserve = 2, conditional store = 3. An accepted request gets its response valid exactly one cycle after acceptance. A read returns the stored word, a write returns 0, and a later read sees the written value.
- R3: A load-reserve returns the word at its address and gives the requester a valid reservation on that address.
- R4: A conditional store whose requester holds a valid reservation on the same address writes its data and returns 1.
- R5: A conditional store from a requester without a valid reservation returns 0 and leaves memory unchanged.
- R6: A conditional store to an address other than the reserved one returns 0 and leaves memory unchanged.
- R7: A conditional store clears its requester's reservation whether it succeeds or fails, so an immediate second conditional store returns 0.
- R8: A plain write or a successful conditional store by one requester clears the other requester's reservation on the same address. A write to a different address leaves that reservation in place.
- R9: A requester's own plain write to its reserved address does not clear its own reservation.
- R10: When several requesters are valid in the same cycle, only the lowest-numbered one sees ready. At most one request is accepted per cycle, and ready is never high without valid.
- R11: A new load-reserve replaces the requester's earlier reservation. A conditional store to the old address then fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears memory and reservations |
| req_valid | input | NREQ | Request valid, one bit per requester |
| req_ready | output | NREQ | Request accepted this cycle, one bit per requester |
| req_op | input | NREQ x 2 | Operation code per requester (0 read, 1 write, 2 load-reserve, 3 conditional store) |
| req_addr | input | NREQ x AW | Word address per requester |
| req_wdata | input | NREQ x DW | Store data per requester |
| rsp_valid | output | NREQ | Response valid, one cycle after acceptance |
| rsp_data | output | NREQ x DW | Read data, or conditional-store status, or 0 for a write |

## Verification
Ready is combinational from valid, so the bench samples it one time unit after driving the inputs at the falling edge, in the same cycle. Memory, reservations and the response register all update at the accepting rising edge. The response and its data are therefore sampled at the next falling edge, one cycle after acceptance, and a following operation already observes the new memory and reservation state. A bench model applies each accepted operation in grant order and predicts every ready bit, response valid and response word for that sampling point.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } llsc_op_e;
endpackage

// File: rtl/llsc_arbiter.sv
// Fixed-priority grant: lowest index wins.
module llsc_arbiter #(
    parameter int N  = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  valid,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        grant = '0;
        any   = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                any   = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/llsc_word_mem.sv
// Small word memory, cleared by reset, combinational read.
module llsc_word_mem #(
    parameter int AW = 4,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[addr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/llsc_resv_table.sv
// Per-requester reservation registers and conditional-store decision.
module llsc_resv_table
    import llsc_pkg::*;
#(
    parameter int N  = 2,
    parameter int AW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  logic [IW-1:0]        acc_idx,
    input  llsc_op_e             acc_op,
    input  logic [AW-1:0]        acc_addr,
    output logic                 sc_ok,
    output logic                 mem_we,
    output logic [N-1:0]         resv_vld,
    output logic [N-1:0][AW-1:0] resv_addr
);
    typedef struct packed {
        logic [N-1:0]         vld;
        logic [N-1:0][AW-1:0] addr;
    } resv_t;

    resv_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        sc_ok  = st_q.vld[acc_idx] && (st_q.addr[acc_idx] == acc_addr);
        mem_we = acc && ((acc_op == OP_WRITE) || ((acc_op == OP_COND) && sc_ok));
        if (acc) begin
            if (acc_op == OP_LINK) begin
                st_d.vld[acc_idx]  = 1'b1;
                st_d.addr[acc_idx] = acc_addr;
            end
            if (acc_op == OP_COND) begin
                st_d.vld[acc_idx] = 1'b0;
            end
        end
        // a committed store cancels every other holder of that address
        for (int i = 0; i < N; i++) begin
            if (mem_we && (IW'(i) != acc_idx) && (st_q.addr[i] == acc_addr)) begin
                st_d.vld[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resv_vld  = st_q.vld;
    assign resv_addr = st_q.addr;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NREQ = 2,
    parameter int AW   = 4,
    parameter int DW   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        req_valid,
    output logic [NREQ-1:0]        req_ready,
    input  logic [NREQ-1:0][1:0]   req_op,
    input  logic [NREQ-1:0][AW-1:0] req_addr,
    input  logic [NREQ-1:0][DW-1:0] req_wdata,
    output logic [NREQ-1:0]        rsp_valid,
    output logic [NREQ-1:0][DW-1:0] rsp_data
);
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

    typedef struct packed {
        logic [NREQ-1:0]         vld;
        logic [NREQ-1:0][DW-1:0] data;
    } rsp_t;

    rsp_t rsp_q, rsp_d;

    logic [NREQ-1:0]         grant;
    logic                    any;
    logic [IW-1:0]           idx;
    llsc_op_e                sel_op;
    logic [AW-1:0]           sel_addr;
    logic [DW-1:0]           sel_wdata;
    logic                    sc_ok;
    logic                    mem_we;
    logic [DW-1:0]           rdata;
    logic [DW-1:0]           result;
    logic [NREQ-1:0]         resv_vld;
    logic [NREQ-1:0][AW-1:0] resv_addr;

    llsc_arbiter #(.N(NREQ)) u_arb (
        .valid (req_valid),
        .grant (grant),
        .any   (any),
        .idx   (idx)
    );

    assign sel_op    = llsc_op_e'(req_op[idx]);
    assign sel_addr  = req_addr[idx];
    assign sel_wdata = req_wdata[idx];

    llsc_resv_table #(.N(NREQ), .AW(AW)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (any),
        .acc_idx   (idx),
        .acc_op    (sel_op),
        .acc_addr  (sel_addr),
        .sc_ok     (sc_ok),
        .mem_we    (mem_we),
        .resv_vld  (resv_vld),
        .resv_addr (resv_addr)
    );

    llsc_word_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (rdata)
    );

    always_comb begin
        unique case (sel_op)
            OP_READ, OP_LINK: result = rdata;
            OP_COND:          result = DW'(sc_ok);
            default:          result = '0;
        endcase
        rsp_d.vld = grant;
        for (int i = 0; i < NREQ; i++) begin
            rsp_d.data[i] = grant[i] ? result : rsp_q.data[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign req_ready = grant;
    assign rsp_valid = rsp_q.vld;
    assign rsp_data  = rsp_q.data;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int NREQ = 2,
    parameter int AW   = 4,
    parameter int DW   = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NREQ-1:0]         req_valid,
    input logic [NREQ-1:0]         req_ready,
    input logic [NREQ-1:0][1:0]    req_op,
    input logic [NREQ-1:0][AW-1:0] req_addr,
    input logic [NREQ-1:0]         rsp_valid,
    input logic [NREQ-1:0][DW-1:0] rsp_data,
    input logic [NREQ-1:0]         resv_vld,
    input logic [NREQ-1:0][AW-1:0] resv_addr
);
    a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    a_r10_low_index_first: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |-> req_ready[0]);

    for (genvar i = 0; i < NREQ; i++) begin : g_req
        a_r10_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
            req_ready[i] |-> req_valid[i]);

        a_r2_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_ready[i]) |=> rsp_valid[i]);

        a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_valid[i] && req_ready[i]) |=> !rsp_valid[i]);

        a_r3_link_reserves: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_ready[i] && req_op[i] == 2'd2)
            |=> (resv_vld[i] && resv_addr[i] == $past(req_addr[i])));

        a_r7_cond_consumes: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_ready[i] && req_op[i] == 2'd3) |=> !resv_vld[i]);

        a_r5_cond_without_resv_fails: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_ready[i] && req_op[i] == 2'd3 && !resv_vld[i])
            |=> (rsp_data[i] == '0));

        a_r6_cond_wrong_addr_fails: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_ready[i] && req_op[i] == 2'd3 && resv_addr[i] != req_addr[i])
            |=> (rsp_data[i] == '0));

        a_r4_cond_status_is_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_ready[i] && req_op[i] == 2'd3) |=> (rsp_data[i] <= 1));
    end
endmodule

bind llsc_monitor llsc_monitor_chk #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
    localparam int NREQ = 2;
    localparam int AW   = 4;
    localparam int DW   = 32;
    localparam int DEPTH = 1 << AW;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NREQ-1:0]         req_valid = '0;
    logic [NREQ-1:0]         req_ready;
    logic [NREQ-1:0][1:0]    req_op = '0;
    logic [NREQ-1:0][AW-1:0] req_addr = '0;
    logic [NREQ-1:0][DW-1:0] req_wdata = '0;
    logic [NREQ-1:0]         rsp_valid;
    logic [NREQ-1:0][DW-1:0] rsp_data;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] m_mem [DEPTH];
    logic          m_rv  [NREQ];
    logic [AW-1:0] m_ra  [NREQ];

    always #2 clk = ~clk;

    llsc_monitor #(.NREQ(NREQ), .AW(AW), .DW(DW)) dut (.*);

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Model of one accepted operation; returns expected response word.
    function automatic logic [DW-1:0] model_op(input int g, input int op,
                                               input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] r;
        logic ok;
        logic wr;
        r = '0;
        wr = 1'b0;
        case (op)
            0: r = m_mem[a];
            1: begin m_mem[a] = d; wr = 1'b1; end
            2: begin r = m_mem[a]; m_rv[g] = 1'b1; m_ra[g] = a; end
            default: begin
                ok = m_rv[g] && (m_ra[g] == a);
                m_rv[g] = 1'b0;
                if (ok) begin m_mem[a] = d; wr = 1'b1; end
                r = DW'(ok);
            end
        endcase
        if (wr) begin
            for (int k = 0; k < NREQ; k++)
                if (k != g && m_ra[k] == a) m_rv[k] = 1'b0;
        end
        return r;
    endfunction

    // Starts and ends at a falling edge; one clock per call.
    task automatic step(input string tag,
                        input logic v0, input int op0, input int a0, input logic [DW-1:0] d0,
                        input logic v1, input int op1, input int a1, input logic [DW-1:0] d1);
        int g;
        logic [DW-1:0] exp;
        req_valid = {v1, v0};
        req_op[0] = op0[1:0];   req_op[1] = op1[1:0];
        req_addr[0] = a0[AW-1:0]; req_addr[1] = a1[AW-1:0];
        req_wdata[0] = d0;      req_wdata[1] = d1;
        #1;
        g = v0 ? 0 : (v1 ? 1 : -1);
        check(tag, "ready (R10)", DW'(req_ready),
              DW'((g == 0) ? 2'b01 : (g == 1) ? 2'b10 : 2'b00));
        exp = '0;
        if (g == 0) exp = model_op(0, op0, a0[AW-1:0], d0);
        if (g == 1) exp = model_op(1, op1, a1[AW-1:0], d1);
        @(negedge clk);
        check(tag, "rsp_valid (R2)", DW'(rsp_valid),
              DW'((g == 0) ? 2'b01 : (g == 1) ? 2'b10 : 2'b00));
        if (g >= 0) check(tag, "rsp_data", rsp_data[g], exp);
    endtask

    task automatic op1req(input string tag, input int r, input int op, input int a,
                          input logic [DW-1:0] d);
        if (r == 0) step(tag, 1'b1, op, a, d, 1'b0, 0, 0, '0);
        else        step(tag, 1'b0, 0, 0, '0, 1'b1, op, a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        for (int i = 0; i < NREQ; i++) begin m_rv[i] = 1'b0; m_ra[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rsp_valid after reset", DW'(rsp_valid), '0);

        op1req("R1", 0, 0, 5, '0);               // memory cleared
        op1req("R1", 1, 3, 3, 32'h55);           // no reservation after reset
        op1req("R5", 0, 0, 3, '0);               // no write happened
        op1req("R2", 0, 1, 2, 32'hAAAA);
        op1req("R2", 1, 0, 2, '0);
        op1req("R3", 0, 2, 2, '0);
        op1req("R4", 0, 3, 2, 32'h1234);
        op1req("R4", 1, 0, 2, '0);
        op1req("R7", 0, 3, 2, 32'h9999);
        op1req("R7", 0, 0, 2, '0);
        op1req("R6", 0, 2, 4, '0);
        op1req("R6", 0, 3, 5, 32'h77);
        op1req("R6", 1, 0, 5, '0);
        op1req("R8", 0, 2, 6, '0);
        op1req("R8", 1, 1, 6, 32'h66);
        op1req("R8", 0, 3, 6, 32'h67);
        op1req("R8", 0, 2, 7, '0);
        op1req("R8", 1, 2, 7, '0);
        op1req("R8", 1, 3, 7, 32'h71);
        op1req("R8", 0, 3, 7, 32'h72);
        op1req("R8", 0, 0, 7, '0);
        op1req("R8", 0, 2, 8, '0);
        op1req("R8", 1, 1, 9, 32'h90);
        op1req("R8", 0, 3, 8, 32'h80);
        op1req("R9", 1, 2, 10, '0);
        op1req("R9", 1, 1, 10, 32'hA0);
        op1req("R9", 1, 3, 10, 32'hA1);
        op1req("R11", 0, 2, 11, '0);
        op1req("R11", 0, 2, 12, '0);
        op1req("R11", 0, 3, 11, 32'hB0);
        op1req("R11", 0, 0, 11, '0);
        // simultaneous requests: requester 0 first, requester 1 held
        step("R10", 1'b1, 0, 2, '0, 1'b1, 1, 2, 32'hC0);
        step("R10", 1'b0, 0, 0, '0, 1'b1, 1, 2, 32'hC0);
        step("R10", 1'b1, 2, 13, '0, 1'b1, 2, 13, '0);
        step("R10", 1'b1, 3, 13, 32'hD0, 1'b1, 2, 13, '0);
        step("R10", 1'b0, 0, 0, '0, 1'b1, 2, 13, '0);
        step("R10", 1'b0, 0, 0, '0, 1'b0, 0, 0, '0);

        for (int n = 0; n < 600; n++) begin
            int o0, o1;
            o0 = $urandom % 4;
            o1 = $urandom % 4;
            step((o0 == 3 || o1 == 3) ? "R4" : "R2",
                 1'($urandom % 2), o0, $urandom % 4, $urandom,
                 1'($urandom % 2), o1, $urandom % 4, $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule